// File: doc/BRIEF.md
# Test-and-Set Shared Semaphore Register

This block holds a single 16-bit semaphore value shared by four host functions, together with a test-and-set flag. Reading the register has a side effect. The read returns the flag as it was and then leaves the flag set. As a result, only the first reader after a clear sees the flag at 0. The identity of the calling function is not carried in the data. It is taken from two address bits of each request.

On top of the raw read and write, the block carries out the whole lock protocol in hardware, one request per cycle. It can initialise the lock, take it, give it back, update the 8-bit implementation state under a read grant, and answer a busy query. Every request is answered one cycle later with a status code, the value and flag as they stood before the request, the caller's ID and a busy indication. Failed operations leave the register and the flag untouched.

Layout of the shared value:

| Bits | Field |
|------|-------|
| 1:0 | lock state (0 = RESET, 1 = FREE, 2 = BUSY, 3 = invalid) |
| 3:2 | owner ID |
| 11:4 | implementation state |
| 15:12 | per-function state |

Top module: `tas_sema`

## Requirements
- R1: After an asynchronous reset, the shared value is 0x0000, the flag is 0, and `rsp_vld` is 0.
- R2: A read (op 1) returns the current value and flag. Afterwards the flag is 1, so a second read returns flag 1.
- R3: `rsp_fid` carries bits 26:25 of `req_addr` for every request, whatever the other address bits are.
- R4: A raw write (op 2) replaces all 16 bits. The flag is cleared only when `req_wtas` is 0; a write with `req_wtas` = 1 leaves the flag as it was.
- R5: A take-lock request (op 3) succeeds only when the flag is 0 and the state is FREE. On success, the state becomes BUSY (2), bits 3:2 take the caller's ID, and the status is 0.
- R6: A failed take-lock changes nothing. Its status is chosen in this order: flag set gives 1, state RESET gives 2, state BUSY gives 3, state code 3 gives 4.
- R7: A release (op 4) returns the state to FREE and keeps the owner bits, but only when the flag is 0, the state is BUSY and the caller is the recorded owner. If the flag is set, the status is 1; otherwise a failure gives status 5.
- R8: An implementation-state set (op 5) is accepted only from the function whose latest read saw the flag at 0. A raw write or a successful set withdraws that grant. On success, the set loads `req_wdata[7:0]` into bits 11:4 and clears the flag. A set without the grant returns status 6 and changes nothing.
- R9: A busy query (op 6) returns `rsp_busy` = 1 when the flag is set or the state is BUSY. It changes neither the flag nor the value.
- R10: An initialise request (op 7) sets the state to FREE when the flag is 0. When the flag is set, it returns status 1 and changes nothing.
- R11: `rsp_vld` is 1 exactly in the cycle after a non-idle request. `rsp_data` and `rsp_tas` show the pre-request value and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_op | input | 3 | request: 0 idle, 1 read, 2 write, 3 take lock, 4 release, 5 set impl state, 6 busy query, 7 initialise |
| req_addr | input | 27 | request address; bits 26:25 select the calling function |
| req_wdata | input | 16 | write value (op 2) or implementation state in bits 7:0 (op 5) |
| req_wtas | input | 1 | flag bit written by op 2; 0 clears the flag |
| rsp_vld | output | 1 | response valid |
| rsp_status | output | 3 | 0 ok, 1 flag taken, 2 state RESET, 3 state BUSY, 4 invalid code, 5 not owner, 6 no grant |
| rsp_data | output | 16 | shared value before the request |
| rsp_tas | output | 1 | flag before the request |
| rsp_fid | output | 2 | ID of the calling function |
| rsp_busy | output | 1 | busy answer to op 6, 0 for other ops |

## Verification
A stimulus table walks the lock through its life. It starts at RESET, goes to FREE by initialisation, and is then read by two functions in turn. This shows that the first reader alone obtains the grant and a clear flag. The same walk sends take-lock requests against each state code and against a set flag, which checks the failure priority. Releases from a foreign owner and from the true owner separate the ownership check from the state check. Directed tests then place noise on the unrelated address bits, assert reset in the middle of the sequence, and try to initialise while the flag is held.

// File: rtl/tas_sema_pkg.sv
package tas_sema_pkg;
  localparam int SV_W     = 16;
  localparam int ST_LSB   = 0;
  localparam int ST_W     = 2;
  localparam int OWN_LSB  = 2;
  localparam int OWN_W    = 2;
  localparam int IMPL_LSB = 4;
  localparam int IMPL_W   = 8;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_LOCK    = 3'd3,
    OP_FREE    = 3'd4,
    OP_SETIMPL = 3'd5,
    OP_BUSYQ   = 3'd6,
    OP_INIT    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    RS_OK       = 3'd0,
    RS_TAS      = 3'd1,
    RS_IN_RESET = 3'd2,
    RS_HELD     = 3'd3,
    RS_BADCODE  = 3'd4,
    RS_NOTOWNER = 3'd5,
    RS_NOGRANT  = 3'd6
  } sts_e;

  typedef enum logic [1:0] {
    LK_RESET = 2'd0,
    LK_FREE  = 2'd1,
    LK_BUSY  = 2'd2,
    LK_BAD   = 2'd3
  } lk_e;
endpackage

// File: rtl/tas_sema_fid.sv
module tas_sema_fid #(
  parameter int ADDR_W  = 27,
  parameter int FID_LSB = 25,
  parameter int FID_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FID_W-1:0]  fid
);
  logic unused_addr;

  assign fid         = addr[FID_LSB +: FID_W];
  assign unused_addr = ^addr;
endmodule

// File: rtl/tas_sema_ctl.sv
module tas_sema_ctl
  import tas_sema_pkg::*;
#(
  parameter int FID_W = OWN_W
) (
  input  logic [2:0]       op,
  input  logic [FID_W-1:0] fid,
  input  logic [SV_W-1:0]  wdata,
  input  logic             wtas,
  input  logic [SV_W-1:0]  cur_sv,
  input  logic             cur_tas,
  input  logic             cur_grant,
  input  logic [FID_W-1:0] cur_gfid,
  output logic [SV_W-1:0]  nxt_sv,
  output logic             nxt_tas,
  output logic             nxt_grant,
  output logic [FID_W-1:0] nxt_gfid,
  output logic [2:0]       sts,
  output logic             busy
);
  op_e              op_q;
  lk_e              lk;
  logic [FID_W-1:0] owner;

  assign op_q  = op_e'(op);
  assign lk    = lk_e'(cur_sv[ST_LSB +: ST_W]);
  assign owner = cur_sv[OWN_LSB +: FID_W];

  always_comb begin
    nxt_sv    = cur_sv;
    nxt_tas   = cur_tas;
    nxt_grant = cur_grant;
    nxt_gfid  = cur_gfid;
    sts       = RS_OK;
    busy      = 1'b0;
    unique case (op_q)
      OP_READ: begin
        nxt_tas = 1'b1;
        if (!cur_tas) begin
          nxt_grant = 1'b1;
          nxt_gfid  = fid;
        end
      end
      OP_WRITE: begin
        nxt_sv    = wdata;
        nxt_grant = 1'b0;
        if (!wtas) nxt_tas = 1'b0;
      end
      OP_LOCK: begin
        if (cur_tas) sts = RS_TAS;
        else begin
          unique case (lk)
            LK_RESET: sts = RS_IN_RESET;
            LK_BUSY:  sts = RS_HELD;
            LK_BAD:   sts = RS_BADCODE;
            LK_FREE: begin
              nxt_sv[ST_LSB +: ST_W]   = LK_BUSY;
              nxt_sv[OWN_LSB +: FID_W] = fid;
            end
          endcase
        end
      end
      OP_FREE: begin
        if (cur_tas) sts = RS_TAS;
        else if (lk != LK_BUSY || owner != fid) sts = RS_NOTOWNER;
        else nxt_sv[ST_LSB +: ST_W] = LK_FREE;
      end
      OP_SETIMPL: begin
        if (cur_grant && cur_gfid == fid) begin
          nxt_sv[IMPL_LSB +: IMPL_W] = wdata[IMPL_W-1:0];
          nxt_tas   = 1'b0;
          nxt_grant = 1'b0;
        end else begin
          sts = RS_NOGRANT;
        end
      end
      OP_BUSYQ: busy = cur_tas | (lk == LK_BUSY);
      OP_INIT: begin
        if (cur_tas) sts = RS_TAS;
        else nxt_sv[ST_LSB +: ST_W] = LK_FREE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tas_sema_regs.sv
module tas_sema_regs
  import tas_sema_pkg::*;
#(
  parameter int FID_W = OWN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SV_W-1:0]  nxt_sv,
  input  logic             nxt_tas,
  input  logic             nxt_grant,
  input  logic [FID_W-1:0] nxt_gfid,
  input  logic [2:0]       nxt_sts,
  input  logic             nxt_busy,
  input  logic [FID_W-1:0] cur_fid,
  output logic [SV_W-1:0]  sv_q,
  output logic             tas_q,
  output logic             grant_q,
  output logic [FID_W-1:0] gfid_q,
  output logic             rsp_vld,
  output logic [2:0]       rsp_status,
  output logic [SV_W-1:0]  rsp_data,
  output logic             rsp_tas,
  output logic [FID_W-1:0] rsp_fid,
  output logic             rsp_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q    <= '0;
      tas_q   <= 1'b0;
      grant_q <= 1'b0;
      gfid_q  <= '0;
    end else if (en) begin
      sv_q    <= nxt_sv;
      tas_q   <= nxt_tas;
      grant_q <= nxt_grant;
      gfid_q  <= nxt_gfid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vld <= 1'b0;
    else        rsp_vld <= en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_status <= '0;
      rsp_data   <= '0;
      rsp_tas    <= 1'b0;
      rsp_fid    <= '0;
      rsp_busy   <= 1'b0;
    end else if (en) begin
      rsp_status <= nxt_sts;
      rsp_data   <= sv_q;
      rsp_tas    <= tas_q;
      rsp_fid    <= cur_fid;
      rsp_busy   <= nxt_busy;
    end
  end
endmodule

// File: rtl/tas_sema.sv
module tas_sema
  import tas_sema_pkg::*;
#(
  parameter int ADDR_W  = 27,
  parameter int FID_LSB = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SV_W-1:0]     req_wdata,
  input  logic                req_wtas,
  output logic                rsp_vld,
  output logic [2:0]          rsp_status,
  output logic [SV_W-1:0]     rsp_data,
  output logic                rsp_tas,
  output logic [OWN_W-1:0]    rsp_fid,
  output logic                rsp_busy
);
  localparam int FID_W = OWN_W;

  logic [FID_W-1:0] fid;
  logic [SV_W-1:0]  sv_q, nxt_sv;
  logic             tas_q, nxt_tas;
  logic             grant_q, nxt_grant;
  logic [FID_W-1:0] gfid_q, nxt_gfid;
  logic [2:0]       nxt_sts;
  logic             nxt_busy;
  logic             en;

  assign en = (req_op != OP_IDLE);

  tas_sema_fid #(.ADDR_W(ADDR_W), .FID_LSB(FID_LSB), .FID_W(FID_W)) i_fid (
    .addr (req_addr),
    .fid  (fid)
  );

  tas_sema_ctl #(.FID_W(FID_W)) i_ctl (
    .op        (req_op),
    .fid       (fid),
    .wdata     (req_wdata),
    .wtas      (req_wtas),
    .cur_sv    (sv_q),
    .cur_tas   (tas_q),
    .cur_grant (grant_q),
    .cur_gfid  (gfid_q),
    .nxt_sv    (nxt_sv),
    .nxt_tas   (nxt_tas),
    .nxt_grant (nxt_grant),
    .nxt_gfid  (nxt_gfid),
    .sts       (nxt_sts),
    .busy      (nxt_busy)
  );

  tas_sema_regs #(.FID_W(FID_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .nxt_sv     (nxt_sv),
    .nxt_tas    (nxt_tas),
    .nxt_grant  (nxt_grant),
    .nxt_gfid   (nxt_gfid),
    .nxt_sts    (nxt_sts),
    .nxt_busy   (nxt_busy),
    .cur_fid    (fid),
    .sv_q       (sv_q),
    .tas_q      (tas_q),
    .grant_q    (grant_q),
    .gfid_q     (gfid_q),
    .rsp_vld    (rsp_vld),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .rsp_tas    (rsp_tas),
    .rsp_fid    (rsp_fid),
    .rsp_busy   (rsp_busy)
  );
endmodule

// File: rtl/tas_sema_chk.sv
module tas_sema_chk
  import tas_sema_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      req_op,
  input logic            rsp_vld,
  input logic [2:0]      rsp_status,
  input logic            rsp_tas,
  input logic [OWN_W-1:0] rsp_fid,
  input logic [SV_W-1:0] sv_q,
  input logic            tas_q
);
  p_vld_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op != OP_IDLE) |=> rsp_vld);

  p_no_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_IDLE) |=> !rsp_vld);

  p_read_sets_tas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_READ) |=> tas_q);

  p_busyq_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_BUSYQ) |=> (tas_q == $past(tas_q) && sv_q == $past(sv_q)));

  p_fail_holds_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_status != RS_OK) |-> (sv_q == $past(sv_q)));

  p_lock_grants_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_LOCK && !tas_q && sv_q[ST_LSB +: ST_W] == LK_FREE)
      |=> (rsp_status == RS_OK && sv_q[ST_LSB +: ST_W] == LK_BUSY
           && sv_q[OWN_LSB +: OWN_W] == rsp_fid));

  p_tas_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_tas && $past(req_op) == OP_LOCK) |-> (rsp_status == RS_TAS));

  p_free_by_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && $past(req_op) == OP_FREE && rsp_status == RS_OK)
      |-> ($past(sv_q[OWN_LSB +: OWN_W]) == rsp_fid));
endmodule

bind tas_sema tas_sema_chk i_tas_sema_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_op     (req_op),
  .rsp_vld    (rsp_vld),
  .rsp_status (rsp_status),
  .rsp_tas    (rsp_tas),
  .rsp_fid    (rsp_fid),
  .sv_q       (sv_q),
  .tas_q      (tas_q)
);

// File: tb/test_tas_sema.sv
module test_tas_sema;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [1:0]  fid;
    logic [15:0] wd;
    logic        wt;
    logic [2:0]  st;
    logic [15:0] dat;
    logic        tas;
    logic        busy;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd6,  3'd3, 2'd0, 16'h0000, 1'b1, 3'd2, 16'h0000, 1'b0, 1'b0}, // R6 lock while RESET
    '{4'd10, 3'd7, 2'd0, 16'h0000, 1'b1, 3'd0, 16'h0000, 1'b0, 1'b0}, // R10 init
    '{4'd2,  3'd1, 2'd1, 16'h0000, 1'b1, 3'd0, 16'h0001, 1'b0, 1'b0}, // R2 first read
    '{4'd2,  3'd1, 2'd2, 16'h0000, 1'b1, 3'd0, 16'h0001, 1'b1, 1'b0}, // R2 second read
    '{4'd6,  3'd3, 2'd2, 16'h0000, 1'b1, 3'd1, 16'h0001, 1'b1, 1'b0}, // R6 flag taken
    '{4'd8,  3'd5, 2'd2, 16'h00A5, 1'b1, 3'd6, 16'h0001, 1'b1, 1'b0}, // R8 wrong fid
    '{4'd8,  3'd5, 2'd1, 16'h00A5, 1'b1, 3'd0, 16'h0001, 1'b1, 1'b0}, // R8 grant holder
    '{4'd9,  3'd6, 2'd3, 16'h0000, 1'b1, 3'd0, 16'h0A51, 1'b0, 1'b0}, // R9 idle
    '{4'd5,  3'd3, 2'd3, 16'h0000, 1'b1, 3'd0, 16'h0A51, 1'b0, 1'b0}, // R5 lock ok
    '{4'd9,  3'd6, 2'd2, 16'h0000, 1'b1, 3'd0, 16'h0A5E, 1'b0, 1'b1}, // R9 held
    '{4'd6,  3'd3, 2'd0, 16'h0000, 1'b1, 3'd3, 16'h0A5E, 1'b0, 1'b0}, // R6 BUSY
    '{4'd7,  3'd4, 2'd1, 16'h0000, 1'b1, 3'd5, 16'h0A5E, 1'b0, 1'b0}, // R7 foreign
    '{4'd7,  3'd4, 2'd3, 16'h0000, 1'b1, 3'd0, 16'h0A5E, 1'b0, 1'b0}, // R7 owner
    '{4'd4,  3'd2, 2'd0, 16'hF0A3, 1'b1, 3'd0, 16'h0A5D, 1'b0, 1'b0}, // R4 write
    '{4'd6,  3'd3, 2'd0, 16'h0000, 1'b1, 3'd4, 16'hF0A3, 1'b0, 1'b0}, // R6 code 3
    '{4'd2,  3'd1, 2'd0, 16'h0000, 1'b1, 3'd0, 16'hF0A3, 1'b0, 1'b0}, // R2
    '{4'd9,  3'd6, 2'd0, 16'h0000, 1'b1, 3'd0, 16'hF0A3, 1'b1, 1'b1}, // R9 flag set
    '{4'd7,  3'd4, 2'd0, 16'h0000, 1'b1, 3'd1, 16'hF0A3, 1'b1, 1'b0}, // R7 flag set
    '{4'd4,  3'd2, 2'd2, 16'h0005, 1'b0, 3'd0, 16'hF0A3, 1'b1, 1'b0}, // R4 clear flag
    '{4'd8,  3'd5, 2'd0, 16'h0077, 1'b1, 3'd6, 16'h0005, 1'b0, 1'b0}, // R8 grant withdrawn
    '{4'd2,  3'd1, 2'd3, 16'h0000, 1'b1, 3'd0, 16'h0005, 1'b0, 1'b0}, // R2
    '{4'd9,  3'd6, 2'd3, 16'h0000, 1'b1, 3'd0, 16'h0005, 1'b1, 1'b1}, // R9
    '{4'd4,  3'd2, 2'd1, 16'h0005, 1'b1, 3'd0, 16'h0005, 1'b1, 1'b0}, // R4 wtas=1
    '{4'd4,  3'd1, 2'd1, 16'h0000, 1'b1, 3'd0, 16'h0005, 1'b1, 1'b0}  // R4 flag kept
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  req_op;
  logic [26:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_wtas;
  logic        rsp_vld;
  logic [2:0]  rsp_status;
  logic [15:0] rsp_data;
  logic        rsp_tas;
  logic [1:0]  rsp_fid;
  logic        rsp_busy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tas_sema i_tas_sema (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wtas(req_wtas), .rsp_vld(rsp_vld),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .rsp_tas(rsp_tas),
    .rsp_fid(rsp_fid), .rsp_busy(rsp_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [26:0] addr,
                       input logic [15:0] wd, input logic wt);
    @(negedge clk);
    req_op = op; req_addr = addr; req_wdata = wd; req_wtas = wt;
    @(negedge clk);
    req_op = 3'd0; req_addr = '0; req_wdata = '0; req_wtas = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_op = 3'd0; req_addr = '0; req_wdata = '0; req_wtas = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_vld after reset", rsp_vld, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, {VEC[i].fid, 25'h0}, VEC[i].wd, VEC[i].wt);
      chk($sformatf("R%0d vec %0d vld", VEC[i].req, i), rsp_vld, 1);
      chk($sformatf("R%0d vec %0d status", VEC[i].req, i), rsp_status, VEC[i].st);
      chk($sformatf("R%0d vec %0d data", VEC[i].req, i), rsp_data, VEC[i].dat);
      chk($sformatf("R%0d vec %0d tas", VEC[i].req, i), rsp_tas, VEC[i].tas);
      chk($sformatf("R%0d vec %0d busy", VEC[i].req, i), rsp_busy, VEC[i].busy);
      chk($sformatf("R3 vec %0d fid", i), rsp_fid, VEC[i].fid);
    end

    // R11: no response in the cycle after an idle
    @(negedge clk);
    chk("R11 idle gives no rsp_vld", rsp_vld, 0);

    // R3: noise on unrelated address bits
    for (int f = 0; f < 4; f++) begin
      issue(3'd6, {f[1:0], 25'h1ABCDEF}, 16'h0, 1'b1);
      chk("R3 fid with address noise", rsp_fid, f[1:0]);
    end

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 rsp_vld in reset", rsp_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
    issue(3'd1, 27'h0, 16'h0, 1'b1);
    chk("R1 value after reset", rsp_data, 16'h0000);
    chk("R1 flag after reset", rsp_tas, 0);

    // R10: init with flag held
    issue(3'd7, 27'h0, 16'h0, 1'b1);
    chk("R10 init with flag set status", rsp_status, 1);
    issue(3'd1, 27'h0, 16'h0, 1'b1);
    chk("R10 state unchanged", rsp_data, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule